// File: doc/BRIEF.md
# Banked Scratchpad Data RAM with Bit Access

This block is the 128-byte internal data memory of a small 8-bit controller core. The core reaches it through three ports that work side by side in the same cycle. The register port takes a 2-bit bank select and a 3-bit register number, and maps them onto the 32-byte working-register area. That area holds four banks of eight bytes. The direct port reaches any byte by a 7-bit address. The bit port takes a 7-bit bit address, which points at one bit inside the 16-byte bit-addressable window. That port reads the bit, or overwrites it while the other seven bits of its byte stay as they were.

All reads come combinationally from the stored array. Writes land on the rising clock edge. The direct port also reports which of the three regions its address lies in. Those regions are working registers (00h–1Fh), the bit window (20h–2Fh) and the general area (30h–7Fh), which the core also uses as stack space. The reset input holds back writes while it is low. It does not clear the contents.

Top module: `scratch_ram`

## Requirements
- R1: The direct port reaches all 128 bytes, addresses 00h–7Fh. `dir_rdata` shows the stored byte at `dir_addr` combinationally. When `dir_we` is high at a rising edge, `dir_wdata` is stored at `dir_addr`.
- R2: The register port uses byte address {2'b00, reg_bank, reg_num}. Bank 0 covers 00h–07h, bank 1 covers 08h–0Fh, bank 2 covers 10h–17h and bank 3 covers 18h–1Fh. `reg_rdata` shows that byte combinationally, and `reg_we` writes `reg_wdata` there at the rising edge.
- R3: A bit address b selects bit b[2:0] of byte 20h + b[6:3]. `bit_rdata` shows that bit combinationally.
- R4: A bit write with `bit_we` high stores `bit_wdata` into the addressed bit at one rising edge. It leaves the other seven bits of that byte and every other byte unchanged.
- R5: Exactly one of `dir_in_regs`, `dir_in_bits` and `dir_in_gp` is high. They are high for 00h–1Fh, 20h–2Fh and 30h–7Fh respectively.
- R6: When the register port and the direct port both write the same byte at one edge, the register port's value is stored.
- R7: When a direct byte write and a bit write hit the same byte at one edge, the stored byte is the direct write data with the addressed bit replaced by `bit_wdata`.
- R8: While `rst_n` is low, no port writes. Asserting or releasing reset does not change the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Active-low; blocks writes while low, keeps contents |
| reg_bank | input | 2 | Working-register bank select |
| reg_num | input | 3 | Register number within the bank |
| reg_we | input | 1 | Register port write enable |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data |
| dir_addr | input | 7 | Direct byte address |
| dir_we | input | 1 | Direct port write enable |
| dir_wdata | input | 8 | Direct port write data |
| dir_rdata | output | 8 | Direct port read data |
| dir_in_regs | output | 1 | Direct address lies in the working-register area |
| dir_in_bits | output | 1 | Direct address lies in the bit window |
| dir_in_gp | output | 1 | Direct address lies in the general area |
| bit_addr | input | 7 | Bit address |
| bit_we | input | 1 | Bit port write enable |
| bit_wdata | input | 1 | Bit port write data |
| bit_rdata | output | 1 | Bit port read data |

## Verification
A direct sweep fills all 128 bytes with address-dependent values and reads them back, which separates address decode faults from data faults. The region flags are swept over every address, so an off-by-one boundary at 1Fh/20h or 2Fh/30h shows up. Register-port reads and writes over all 32 bank/number pairs are cross-checked through the direct port, which catches swapped bank and number bits. Bit reads and bit toggles over all 128 bit addresses, followed by a full byte readback, reveal a wrong byte or bit select and any write that spills into neighbouring bits. Hand-picked same-byte collisions and writes attempted during reset then check the priority and the reset hold.

// File: rtl/scratch_ram.sv
`timescale 1ns/1ps
module scratch_ram #(
  parameter int DW        = 8,
  parameter int AW        = 7,
  parameter int BANK_W    = 2,
  parameter int REG_W     = 3,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16,
  localparam int DEPTH    = 1 << AW,
  localparam int REG_TOP  = 1 << (BANK_W + REG_W),
  localparam int GP_BASE  = BIT_BASE + BIT_BYTES,
  localparam int SEL_W    = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] reg_bank,
  input  logic [REG_W-1:0]  reg_num,
  input  logic              reg_we,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [AW-1:0]     dir_addr,
  input  logic              dir_we,
  input  logic [DW-1:0]     dir_wdata,
  output logic [DW-1:0]     dir_rdata,
  output logic              dir_in_regs,
  output logic              dir_in_bits,
  output logic              dir_in_gp,
  input  logic [AW-1:0]     bit_addr,
  input  logic              bit_we,
  input  logic              bit_wdata,
  output logic              bit_rdata
);
  logic [DW-1:0] mem [DEPTH];

  logic [AW-1:0]    reg_addr;
  logic [AW-1:0]    bit_byte;
  logic [SEL_W-1:0] bit_sel;
  logic [DW-1:0]    bit_base;
  logic [DW-1:0]    bit_merged;

  assign reg_addr = AW'({reg_bank, reg_num});
  assign bit_byte = AW'(BIT_BASE) + AW'(bit_addr[AW-1:SEL_W]);
  assign bit_sel  = bit_addr[SEL_W-1:0];

  assign reg_rdata = mem[reg_addr];
  assign dir_rdata = mem[dir_addr];
  assign bit_rdata = mem[bit_byte][bit_sel];

  assign dir_in_regs = int'(dir_addr) < REG_TOP;
  assign dir_in_bits = int'(dir_addr) >= BIT_BASE && int'(dir_addr) < GP_BASE;
  assign dir_in_gp   = int'(dir_addr) >= GP_BASE;

  // a bit write lands on top of any same-cycle byte write to its byte
  always_comb begin
    bit_base = mem[bit_byte];
    if (dir_we && dir_addr == bit_byte) bit_base = dir_wdata;
    if (reg_we && reg_addr == bit_byte) bit_base = reg_wdata;
    bit_merged = bit_base;
    bit_merged[bit_sel] = bit_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (dir_we) mem[dir_addr] <= dir_wdata;
      if (reg_we) mem[reg_addr] <= reg_wdata;
      if (bit_we) mem[bit_byte] <= bit_merged;
    end
  end
endmodule

module scratch_ram_chk #(
  parameter int DW       = 8,
  parameter int AW       = 7,
  parameter int BANK_W   = 2,
  parameter int REG_W    = 3,
  parameter int BIT_BASE = 32,
  localparam int SEL_W   = $clog2(DW)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BANK_W-1:0] reg_bank,
  input logic [REG_W-1:0]  reg_num,
  input logic              reg_we,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic [AW-1:0]     dir_addr,
  input logic              dir_we,
  input logic [DW-1:0]     dir_wdata,
  input logic [DW-1:0]     dir_rdata,
  input logic              dir_in_regs,
  input logic              dir_in_bits,
  input logic              dir_in_gp,
  input logic [AW-1:0]     bit_addr,
  input logic              bit_we,
  input logic              bit_wdata,
  input logic              bit_rdata
);
  logic [AW-1:0] c_reg;
  logic [AW-1:0] c_bit;
  assign c_reg = AW'(reg_bank) * AW'(1 << REG_W) + AW'(reg_num);
  assign c_bit = AW'(BIT_BASE + int'(bit_addr) / DW);

  AST_REG_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    dir_addr == c_reg |-> reg_rdata == dir_rdata); // R2
  AST_BIT_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    dir_addr == c_bit |-> bit_rdata == dir_rdata[bit_addr[SEL_W-1:0]]); // R3
  AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dir_in_regs, dir_in_bits, dir_in_gp}) == 1); // R5
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we && !(reg_we && c_reg == dir_addr) && !(bit_we && c_bit == dir_addr)
    |=> dir_addr != $past(dir_addr) || dir_rdata == $past(dir_wdata)); // R1
  AST_REG_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && dir_we && c_reg == dir_addr
    |=> dir_addr != $past(dir_addr) || dir_rdata == $past(reg_wdata)); // R6
  AST_BIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_we |=> bit_addr != $past(bit_addr) || bit_rdata == $past(bit_wdata)); // R4
endmodule

bind scratch_ram scratch_ram_chk #(.DW(DW), .AW(AW), .BANK_W(BANK_W), .REG_W(REG_W),
  .BIT_BASE(BIT_BASE)) u_chk (.*);

// File: tb/tb_scratch_ram.sv
`timescale 1ns/1ps
module tb_scratch_ram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_bank = '0;
  logic [2:0] reg_num = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [6:0] dir_addr = '0;
  logic dir_we = 1'b0;
  logic [7:0] dir_wdata = '0, dir_rdata;
  logic dir_in_regs, dir_in_bits, dir_in_gp;
  logic [6:0] bit_addr = '0;
  logic bit_we = 1'b0, bit_wdata = 1'b0, bit_rdata;

  logic [7:0] m [128];
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  scratch_ram dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    reg_we = 0; dir_we = 0; bit_we = 0;
    @(negedge clk);
  endtask

  task automatic rd_dir(int a, string tag);
    dir_addr = 7'(a);
    #1;
    chk(tag, dir_rdata, m[a]);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 reset flags", {dir_in_regs, dir_in_bits, dir_in_gp}, 3'b100);
    rst_n = 1;
    @(negedge clk);

    for (int a = 0; a < 128; a++) begin
      m[a] = 8'((a * 37 + 5) & 255);
      dir_addr = 7'(a); dir_wdata = m[a]; dir_we = 1;
      tick();
    end
    for (int a = 0; a < 128; a++) rd_dir(a, "R1 direct readback");

    for (int a = 0; a < 128; a++) begin
      dir_addr = 7'(a);
      #1;
      chk("R5 region flags", {dir_in_regs, dir_in_bits, dir_in_gp},
          {a < 32, a >= 32 && a < 48, a >= 48});
    end

    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++) begin
        reg_bank = 2'(b); reg_num = 3'(n);
        #1;
        chk("R2 register read", reg_rdata, m[b * 8 + n]);
      end
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++) begin
        reg_bank = 2'(b); reg_num = 3'(n);
        reg_wdata = 8'(~((b * 8 + n) * 3)); reg_we = 1;
        m[b * 8 + n] = reg_wdata;
        tick();
      end
    for (int a = 0; a < 32; a++) rd_dir(a, "R2 register write via direct");

    for (int b = 0; b < 128; b++) begin
      bit_addr = 7'(b);
      #1;
      chk("R3 bit read", bit_rdata, m[32 + b / 8][b % 8]);
    end

    for (int b = 0; b < 128; b++) begin
      bit_addr = 7'(b); bit_wdata = ~m[32 + b / 8][b % 8]; bit_we = 1;
      m[32 + b / 8][b % 8] = bit_wdata;
      tick();
      rd_dir(32 + b / 8, "R4 bit write byte");
    end
    for (int a = 0; a < 128; a++) rd_dir(a, "R4 no spill");

    reg_bank = 2'd1; reg_num = 3'd2; reg_wdata = 8'hC3; reg_we = 1;
    dir_addr = 7'h0A; dir_wdata = 8'h3C; dir_we = 1;
    m[8'h0A] = 8'hC3;
    tick();
    rd_dir(8'h0A, "R6 register beats direct");

    dir_addr = 7'h25; dir_wdata = 8'h00; dir_we = 1;
    bit_addr = 7'h2B; bit_wdata = 1; bit_we = 1;
    m[8'h25] = 8'h08;
    tick();
    rd_dir(8'h25, "R7 bit over byte set");
    dir_addr = 7'h2F; dir_wdata = 8'hFF; dir_we = 1;
    bit_addr = 7'h7E; bit_wdata = 0; bit_we = 1;
    m[8'h2F] = 8'hBF;
    tick();
    rd_dir(8'h2F, "R7 bit over byte clear");

    m[8'h70] = 8'h11;
    dir_addr = 7'h70; dir_wdata = 8'h11; dir_we = 1;
    tick();
    rst_n = 0;
    dir_addr = 7'h70; dir_wdata = 8'h22; dir_we = 1;
    reg_bank = 2'd3; reg_num = 3'd7; reg_wdata = ~m[31]; reg_we = 1;
    bit_addr = 7'h00; bit_wdata = ~m[32][0]; bit_we = 1;
    @(posedge clk); @(posedge clk); #1;
    reg_we = 0; dir_we = 0; bit_we = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_dir(8'h70, "R8 direct held in reset");
    rd_dir(31, "R8 register held in reset");
    rd_dir(32, "R8 bit held in reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule